// File: doc/BRIEF.md
# Energy Pulse Width Limiter

This block turns single-cycle energy pulse requests into shaped output pulses on two channels, one for real energy and one for reactive energy. Each output pulse lasts a programmed number of time-base ticks, so an external counter or an optical reader always sees a pulse of known, bounded width. A per-block width code N sets the width to 2N+1 ticks. The code 255 switches the limit off, and each pulse edge then follows the requests directly. One polarity bit selects active-low outputs, which is the default, or active-high outputs for both channels.

A spacing register selects between two ways of working. When it is zero, every request starts its pulse on the next clock, and the width is counted in sample strobes. When it is nonzero, each channel stores requests as a count in a small queue. A pulse then starts only after at least that many base strobes have passed since the previous start, and only once the previous limited pulse has ended. The width is then counted in base strobes. The intended spacing setting for queued use is 81. A request that reaches a full queue is lost, and a sticky per-channel flag records the loss.

Top module: `epl_top`

## Requirements
- R1: After reset both output pins sit at their idle level, both overflow flags are 0 and both queues are empty.
- R2: With `cfg_active_high` = 0 the idle pin level is 1 and the active level is 0. With `cfg_active_high` = 1 both channels use idle 0 and active 1.
- R3: With `cfg_interval` = 0, a request held high for one cycle makes the pin active on the next clock. With a code N other than 255, the pin stays active for exactly 2N+1 `sample_tick` strobes counted from the cycle after the start.
- R4: With `cfg_interval` = 0, a request that arrives while a limited pulse is active keeps the pin active and restarts the count of 2N+1 strobes.
- R5: With `cfg_maxwidth` = 255 no width limit applies, and every pulse start toggles the pin between its active and idle levels.
- R6: With `cfg_interval` nonzero, each cycle with a request stores one entry in that channel's queue of DEPTH (default 4) entries. Every stored entry yields exactly one pulse, and that pulse lasts 2N+1 `base_tick` strobes.
- R7: With `cfg_interval` = I nonzero, a queued pulse starts only after at least I `base_tick` strobes have passed since the previous start on that channel, and only once the previous limited pulse has ended.
- R8: A queued request that arrives while the queue already holds DEPTH entries is dropped. That channel's overflow flag then rises and stays 1 until reset. A burst of one in-flight request plus DEPTH queued requests does not set the flag.
- R9: The two channels are independent: requests on one channel never change the other channel's pin or overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe per sample; width tick when the spacing register is 0 |
| base_tick | input | 1 | One-cycle time-base strobe; width tick and spacing unit in queued use |
| cfg_maxwidth | input | 8 | Width code N: pulse width 2N+1 ticks; 255 removes the limit |
| cfg_interval | input | 8 | Start spacing in base strobes; 0 selects immediate, unqueued pulses |
| cfg_active_high | input | 1 | 1 makes both output pins active high |
| req_real | input | 1 | Pulse request, real-energy channel |
| req_reactive | input | 1 | Pulse request, reactive-energy channel |
| pulse_real | output | 1 | Shaped pulse, real-energy channel |
| pulse_reactive | output | 1 | Shaped pulse, reactive-energy channel |
| ovf_real | output | 1 | Sticky dropped-request flag, real-energy channel |
| ovf_reactive | output | 1 | Sticky dropped-request flag, reactive-energy channel |

## Verification
A wrong queue count shows at the pins as a missing or extra pulse once the queue drains, which takes at most DEPTH spacing windows after the burst. A stuck or misloaded width counter shows on the very pulse it affects as a tick count that differs from 2N+1. A spacing counter that fails to clear on a start shows as two rising edges closer together than the programmed number of base strobes. A bad polarity or toggle state shows on the first clock after the next start. The bench therefore sweeps every small width code in both tick domains and on both channels, and counts strobes and edges directly at the pins.

// File: rtl/epl_pkg.sv
package epl_pkg;
  localparam int CODE_W = 8;
  localparam int SPAN_W = CODE_W + 2;
  localparam logic [CODE_W-1:0] NO_LIMIT_CODE = '1;

  // Width in ticks for a code N: 2N+1
  function automatic logic [SPAN_W-1:0] span_ticks(input logic [CODE_W-1:0] code);
    return (SPAN_W'(code) << 1) + SPAN_W'(1);
  endfunction

  function automatic logic is_unlimited(input logic [CODE_W-1:0] code);
    return code == NO_LIMIT_CODE;
  endfunction
endpackage

// File: rtl/epl_queue.sv
module epl_queue #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] level,
  output logic             nonempty,
  output logic             drop,
  output logic             overflow
);
  logic full;
  logic accept;
  logic take;

  assign full     = (level == CNT_W'(DEPTH));
  assign nonempty = (level != '0);
  assign accept   = push && !full;
  assign drop     = push && full;
  assign take     = pop && nonempty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      case ({accept, take})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
      if (drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/epl_pacer.sv
module epl_pacer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         base_tick,
  input  logic         start,
  input  logic [W-1:0] interval,
  output logic         ready
);
  localparam logic [W-1:0] SAT = '1;
  logic [W-1:0] gap;

  // Base strobes since the last start, saturating; reset full so the first start is free
  always_ff @(posedge clk) begin
    if (!rst_n)                         gap <= SAT;
    else if (start)                     gap <= '0;
    else if (base_tick && gap != SAT)   gap <= gap + W'(1);
  end

  assign ready = (gap >= interval);
endmodule

// File: rtl/epl_shaper.sv
module epl_shaper
  import epl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wtick,
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic              end_evt
);
  logic [SPAN_W-1:0] remain;
  logic              unl;

  assign unl     = is_unlimited(code);
  assign end_evt = !start && wtick && active && !unl && (remain == SPAN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start) begin
      if (unl) begin
        active <= !active;
      end else begin
        active <= 1'b1;
        remain <= span_ticks(code);
      end
    end else if (end_evt) begin
      active <= 1'b0;
    end else if (wtick && active && !unl) begin
      remain <= remain - SPAN_W'(1);
    end
  end
endmodule

// File: rtl/epl_top.sv
module epl_top
  import epl_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CH    = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              base_tick,
  input  logic [CODE_W-1:0] cfg_maxwidth,
  input  logic [CODE_W-1:0] cfg_interval,
  input  logic              cfg_active_high,
  input  logic              req_real,
  input  logic              req_reactive,
  output logic              pulse_real,
  output logic              pulse_reactive,
  output logic              ovf_real,
  output logic              ovf_reactive
);
  logic                       bypass;
  logic                       wtick;
  logic [CH-1:0]              req_vec;
  logic [CH-1:0]              start_evt;
  logic [CH-1:0]              end_evt;
  logic [CH-1:0]              drop_evt;
  logic [CH-1:0]              act_vec;
  logic [CH-1:0]              pin_vec;
  logic [CH-1:0]              ovf_vec;
  logic [CH-1:0][CNT_W-1:0]   qcount;

  assign bypass  = (cfg_interval == '0);
  assign wtick   = bypass ? sample_tick : base_tick;
  assign req_vec = {req_reactive, req_real};

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic push;
    logic pop;
    logic nonempty;
    logic ready;
    logic busy;

    assign push = req_vec[i] && !bypass;
    assign busy = act_vec[i] && !is_unlimited(cfg_maxwidth);
    assign start_evt[i] = bypass ? req_vec[i] : (nonempty && ready && !busy);
    assign pop  = !bypass && start_evt[i];

    epl_queue #(.DEPTH(DEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pop      (pop),
      .level    (qcount[i]),
      .nonempty (nonempty),
      .drop     (drop_evt[i]),
      .overflow (ovf_vec[i])
    );

    epl_pacer #(.W(CODE_W)) u_pacer (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .start     (start_evt[i]),
      .interval  (cfg_interval),
      .ready     (ready)
    );

    epl_shaper u_shaper (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_evt[i]),
      .wtick   (wtick),
      .code    (cfg_maxwidth),
      .active  (act_vec[i]),
      .end_evt (end_evt[i])
    );

    assign pin_vec[i] = cfg_active_high ? act_vec[i] : !act_vec[i];
  end

  assign pulse_real     = pin_vec[0];
  assign pulse_reactive = pin_vec[1];
  assign ovf_real       = ovf_vec[0];
  assign ovf_reactive   = ovf_vec[1];
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int DEPTH = 4,
  parameter int CH    = 2,
  parameter int CNT_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [7:0]               cfg_maxwidth,
  input logic [7:0]               cfg_interval,
  input logic                     cfg_active_high,
  input logic [CH-1:0]            req_vec,
  input logic [CH-1:0]            start_evt,
  input logic [CH-1:0]            drop_evt,
  input logic [CH-1:0]            ovf_vec,
  input logic [CH-1:0]            pin_vec,
  input logic [CH-1:0][CNT_W-1:0] qcount
);
  for (genvar i = 0; i < CH; i++) begin : g_chk
    assert_bypass_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec[i] && cfg_interval == 8'd0 && cfg_maxwidth != 8'hFF) |=>
      (($stable(cfg_active_high) && $stable(cfg_interval)) -> pin_vec[i] == cfg_active_high));

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt[i] && cfg_maxwidth == 8'hFF) |=>
      (($stable(cfg_maxwidth) && $stable(cfg_active_high)) -> pin_vec[i] != $past(pin_vec[i])));

    assert_queue_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      qcount[i] <= CNT_W'(DEPTH));

    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt[i] && cfg_interval != 8'd0) |-> qcount[i] != '0);

    assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt[i] && cfg_interval != 8'd0) |=> ($stable(cfg_interval) -> !start_evt[i]));

    assert_drop_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt[i] |=> ovf_vec[i]);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_vec[i] |=> ovf_vec[i]);
  end
endmodule

bind epl_top epl_checker #(.DEPTH(DEPTH), .CH(CH), .CNT_W(CNT_W)) u_epl_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_maxwidth    (cfg_maxwidth),
  .cfg_interval    (cfg_interval),
  .cfg_active_high (cfg_active_high),
  .req_vec         (req_vec),
  .start_evt       (start_evt),
  .drop_evt        (drop_evt),
  .ovf_vec         (ovf_vec),
  .pin_vec         (pin_vec),
  .qcount          (qcount)
);

// File: tb/epl_top_test.sv
module epl_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       base_tick = 1'b0;
  logic [7:0] cfg_maxwidth = 8'd0;
  logic [7:0] cfg_interval = 8'd0;
  logic       cfg_active_high = 1'b0;
  logic       req_real = 1'b0;
  logic       req_reactive = 1'b0;
  logic       pulse_real, pulse_reactive, ovf_real, ovf_reactive;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int tcnt = 0;

  always #10 clk = ~clk;

  epl_top uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .base_tick(base_tick),
    .cfg_maxwidth(cfg_maxwidth), .cfg_interval(cfg_interval),
    .cfg_active_high(cfg_active_high), .req_real(req_real), .req_reactive(req_reactive),
    .pulse_real(pulse_real), .pulse_reactive(pulse_reactive),
    .ovf_real(ovf_real), .ovf_reactive(ovf_reactive)
  );

  // Tick generators: sample every 5 cycles, base every 2 cycles
  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    sample_tick <= (tcnt % 5 == 0);
    base_tick   <= (tcnt % 2 == 0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic is_act(input int ch);
    logic p;
    p = (ch == 0) ? pulse_real : pulse_reactive;
    return p == cfg_active_high;
  endfunction

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic set_req(input int ch, input logic v);
    if (ch == 0) req_real = v; else req_reactive = v;
  endtask

  task automatic burst(input int ch, input int k);
    for (int j = 0; j < k; j++) begin set_req(ch, 1'b1); step(); end
    set_req(ch, 1'b0);
  endtask

  // Count active sample strobes until the pin returns idle
  task automatic measure_bypass(input int ch, output int ticks);
    int guard = 0;
    ticks = 0;
    while (is_act(ch) && guard < 5000) begin
      if (sample_tick) ticks++;
      step(); guard++;
    end
  endtask

  // Watch a channel in queued use: count pulses, check width and spacing
  task automatic observe(input int ch, input int cycles, input int n, output int pulses);
    logic prev = 1'b0;
    int w = 0;
    int gapt = 0;
    pulses = 0;
    for (int c = 0; c < cycles; c++) begin
      logic a;
      step();
      a = is_act(ch);
      if (a && !prev) begin
        pulses++;
        if (pulses > 1) chk(gapt >= int'(cfg_interval), "R7 spacing", gapt, int'(cfg_interval));
        gapt = 0; w = 0;
      end
      if (!a && prev) chk(w == 2*n+1, "R6 queued width", w, 2*n+1);
      if (a && base_tick) w++;
      if (base_tick) gapt++;
      prev = a;
    end
  endtask

  initial begin
    int t;
    int p;
    repeat (4) step();
    // R1: reset state
    chk(pulse_real == 1'b1 && pulse_reactive == 1'b1, "R1 idle pins", {pulse_reactive, pulse_real}, 3);
    chk(ovf_real == 1'b0 && ovf_reactive == 1'b0, "R1 ovf clear", {ovf_reactive, ovf_real}, 0);
    rst_n = 1'b1;
    step();
    chk(pulse_real == 1'b1, "R2 default idle high", pulse_real, 1);

    // R3: bypass width sweep on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n < 4; n++) begin
        cfg_maxwidth = 8'(n);
        burst(ch, 1);
        chk(is_act(ch), "R3 active next clock", 0, 1);
        chk((ch == 0 ? pulse_real : pulse_reactive) == 1'b0, "R2 active low level", 1, 0);
        measure_bypass(ch, t);
        chk(t == 2*n+1, "R3 bypass width", t, 2*n+1);
        repeat (3) step();
      end
    end

    // R4: retrigger restarts the width count
    cfg_maxwidth = 8'd3;
    burst(0, 1);
    repeat (7) step();
    chk(is_act(0), "R4 still active before retrigger", 0, 1);
    burst(0, 1);
    measure_bypass(0, t);
    chk(t == 7, "R4 retrigger width", t, 7);

    // R2: active-high polarity
    cfg_active_high = 1'b1;
    step();
    chk(pulse_real == 1'b0 && pulse_reactive == 1'b0, "R2 inverted idle", {pulse_reactive, pulse_real}, 0);
    cfg_maxwidth = 8'd1;
    burst(1, 1);
    chk(pulse_reactive == 1'b1, "R2 inverted active", pulse_reactive, 1);
    measure_bypass(1, t);
    chk(t == 3, "R2 inverted width", t, 3);
    cfg_active_high = 1'b0;

    // R5: no limit, toggling
    cfg_maxwidth = 8'd255;
    burst(0, 1);
    repeat (60) step();
    chk(is_act(0), "R5 held without limit", 0, 1);
    chk(!is_act(1), "R9 other channel idle", 1, 0);
    burst(0, 1);
    chk(!is_act(0), "R5 toggled back", 1, 0);

    // R6/R7: queued use, interval 3, widths 0..2
    cfg_interval = 8'd3;
    for (int n = 0; n < 3; n++) begin
      cfg_maxwidth = 8'(n);
      fork
        burst(0, 3);
        observe(0, 200, n, p);
      join
      chk(p == 3, "R6 queued pulse count", p, 3);
    end
    chk(ovf_real == 1'b0, "R8 no overflow small burst", ovf_real, 0);

    // R8: exactly full on reactive, overflow on real, interval 200
    cfg_maxwidth = 8'd0;
    cfg_interval = 8'd200;
    repeat (600) step();
    fork
      burst(1, 5);
      observe(1, 2200, 0, p);
    join
    chk(p == 5, "R8 full burst delivered", p, 5);
    chk(ovf_reactive == 1'b0, "R8 full burst no flag", ovf_reactive, 0);
    repeat (600) step();
    fork
      burst(0, 6);
      observe(0, 2200, 0, p);
    join
    chk(p == 5, "R8 dropped request", p, 5);
    chk(ovf_real == 1'b1, "R8 overflow flag", ovf_real, 1);
    chk(ovf_reactive == 1'b0, "R9 other flag clear", ovf_reactive, 0);
    repeat (50) step();
    chk(ovf_real == 1'b1, "R8 flag sticky", ovf_real, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule